// File: doc/BRIEF.md
# Core Local Reset and Debug-Halt Sequencer

This block sits next to a small pipelined CPU core and controls when that core is held in reset and when it is handed to a debug routine. A hard global reset puts the core into reset at once. A local, core-only reset request goes through a handshake instead. The sequencer first stalls new issue and waits for the core to report an empty pipeline. It then places the core in reset and acknowledges with a one-cycle pulse. While the request stays high, it repeats that pulse on a fixed interval, and with each pulse it issues a dummy fetch from the reset address whose data the core discards.

An external debug request behaves like a breakpoint. The core is redirected to the break address and a debug acknowledge stays high until a resume. While debug owns the core, local reset requests are ignored. They are looked at again only at a release point: a single-step or a resume. All outputs are decoded from registered state, so each one changes only on a clock edge, except during the asynchronous global reset.

Top module: `core_rst_seq`

## Requirements
- R1: While `rst_ni` is low, `core_rst_o` and `stall_o` are 1 and `rst_taken_o`, `dbg_ack_o`, `fetch_vld_o` are 0, taking effect immediately without a clock edge. On the first edge after release, the core leaves reset and `fetch_vld_o`=1 with `fetch_addr_o`=RESET_ADDR and `fetch_discard_o`=0; no `rst_taken_o` pulse is produced for a global reset.
- R2: In the run state, `lrst_req_i`=1 at an edge sets `stall_o`=1 (with `core_rst_o`=0) from that edge on. `core_rst_o` rises only on the edge after an edge at which `pipe_empty_i` was 1 during that stall.
- R3: `rst_taken_o` is 1 for exactly one cycle in the first reset cycle. It is then 1 again in every reset cycle whose index from entry is a multiple of PERIOD, so a stay of N cycles beyond entry gives N/PERIOD+1 pulses (integer division).
- R4: In every cycle with `rst_taken_o`=1 there is a dummy fetch: `fetch_vld_o`=1, `fetch_discard_o`=1, `fetch_addr_o`=RESET_ADDR. No fetch is issued in any other reset cycle.
- R5: The core stays in reset while `lrst_req_i` is 1 at each edge. The first edge that sees it at 0 gives one cycle with `core_rst_o`=0 and a non-discarded fetch from RESET_ADDR, then normal running with `fetch_vld_o`=0.
- R6: In the run state with `lrst_req_i`=0, `dbg_req_i`=1 at an edge gives one cycle with `fetch_vld_o`=1, `fetch_addr_o`=BREAK_ADDR, `fetch_discard_o`=0. It also raises `dbg_ack_o`, which stays 1 until a resume or a global reset.
- R7: `dbg_req_i` while `dbg_ack_o`=1 has no effect: no fetch is issued and `dbg_ack_o` stays 1.
- R8: While paused under debug, `lrst_req_i` is ignored: `stall_o` and `core_rst_o` stay 0 as long as neither `step_i` nor `resume_i` is asserted.
- R9: `resume_i` in the paused state clears `dbg_ack_o` on the next edge. If `lrst_req_i` is 1 at that edge the core goes to the drain stall (`stall_o`=1); otherwise it runs. `resume_i` wins over `step_i`.
- R10: `step_i` in the paused state with `lrst_req_i`=0 gives one cycle of `step_go_o`=1 with `dbg_ack_o` still 1, then paused again. With `lrst_req_i`=1 it clears `dbg_ack_o` and starts the drain stall instead.
- R11: When `lrst_req_i` and `dbg_req_i` are both 1 in the run state, the local reset wins. Debug requests are ignored during the drain stall, the reset state and the restart cycle.
- R12: Once the drain stall has begun, the block enters reset when the pipeline is empty even if `lrst_req_i` was withdrawn, and it stays there at least one cycle (with its pulse).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Global hard reset, asynchronous, active low |
| lrst_req_i | input | 1 | Local core-only reset request, level |
| pipe_empty_i | input | 1 | Core reports no instruction in flight |
| dbg_req_i | input | 1 | Debug halt request |
| step_i | input | 1 | Single-step release from debug |
| resume_i | input | 1 | Full resume from debug |
| core_rst_o | output | 1 | Core held in reset |
| stall_o | output | 1 | Core must not issue new instructions |
| rst_taken_o | output | 1 | Reset-entry acknowledge pulse, repeated while held |
| dbg_ack_o | output | 1 | Core is under debug control |
| step_go_o | output | 1 | One-cycle single-step window |
| fetch_vld_o | output | 1 | Sequencer-issued fetch this cycle |
| fetch_discard_o | output | 1 | Returned data of this fetch is to be dropped |
| fetch_addr_o | output | ADDR_W | Address of the sequencer-issued fetch |

## Verification
The hardest case to reach is a local reset request that arrives while debug owns the core and becomes effective only at a release point. The bench pauses the core first and holds the request through several idle paused cycles to show that it is ignored. It then releases once by single-step and once by resume, each time with the request still high, and checks that the acknowledge drops and the drain stall begins. The repeat pulse is swept over drain delays and hold lengths on a small PERIOD. The expected pulse positions and counts are computed as multiples of that period.

// File: rtl/core_rst_pkg.sv
package core_rst_pkg;

    typedef enum logic [2:0] {
        ST_HRST   = 3'd0,
        ST_LEAVE  = 3'd1,
        ST_RUN    = 3'd2,
        ST_DRAIN  = 3'd3,
        ST_RESET  = 3'd4,
        ST_DENTER = 3'd5,
        ST_DEBUG  = 3'd6,
        ST_STEP   = 3'd7
    } seq_state_e;

    typedef enum logic [1:0] {
        FSEL_NONE  = 2'd0,
        FSEL_RESET = 2'd1,
        FSEL_BREAK = 2'd2
    } fetch_sel_e;

    typedef struct packed {
        seq_state_e st;
    } seq_s;

endpackage

// File: rtl/core_rst_tick.sv
module core_rst_tick #(
    parameter int PERIOD = 16,
    localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic at_zero_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_s;

    tick_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!run_i) begin
            nxt_d.cnt = '0;
        end else if (cur_q.cnt == CNT_W'(PERIOD - 1)) begin
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign at_zero_o = (cur_q.cnt == '0);

endmodule

// File: rtl/core_rst_fetch_mux.sv
module core_rst_fetch_mux
    import core_rst_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    parameter logic [ADDR_W-1:0] BREAK_ADDR = '0
) (
    input  fetch_sel_e        sel_i,
    output logic              vld_o,
    output logic [ADDR_W-1:0] addr_o
);

    always_comb begin
        vld_o  = 1'b0;
        addr_o = '0;
        unique case (sel_i)
            FSEL_RESET: begin
                vld_o  = 1'b1;
                addr_o = RESET_ADDR;
            end
            FSEL_BREAK: begin
                vld_o  = 1'b1;
                addr_o = BREAK_ADDR;
            end
            default: begin
                vld_o  = 1'b0;
                addr_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/core_rst_seq.sv
module core_rst_seq
    import core_rst_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                PERIOD     = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    parameter logic [ADDR_W-1:0] BREAK_ADDR = ADDR_W'(32'h0000_0020)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              lrst_req_i,
    input  logic              pipe_empty_i,
    input  logic              dbg_req_i,
    input  logic              step_i,
    input  logic              resume_i,
    output logic              core_rst_o,
    output logic              stall_o,
    output logic              rst_taken_o,
    output logic              dbg_ack_o,
    output logic              step_go_o,
    output logic              fetch_vld_o,
    output logic              fetch_discard_o,
    output logic [ADDR_W-1:0] fetch_addr_o
);

    seq_s       cur_q, nxt_d;
    logic       in_reset;
    logic       tick_zero;
    logic       beat;
    fetch_sel_e fsel;

    // next-state computation
    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_HRST:   nxt_d.st = ST_LEAVE;
            ST_LEAVE:  nxt_d.st = ST_RUN;
            ST_RUN: begin
                if (lrst_req_i) begin
                    nxt_d.st = ST_DRAIN;
                end else if (dbg_req_i) begin
                    nxt_d.st = ST_DENTER;
                end
            end
            ST_DRAIN: begin
                if (pipe_empty_i) begin
                    nxt_d.st = ST_RESET;
                end
            end
            ST_RESET: begin
                if (!lrst_req_i) begin
                    nxt_d.st = ST_LEAVE;
                end
            end
            ST_DENTER: nxt_d.st = ST_DEBUG;
            ST_DEBUG: begin
                // release points: only here is the local request sampled
                if (resume_i || step_i) begin
                    if (lrst_req_i) begin
                        nxt_d.st = ST_DRAIN;
                    end else if (resume_i) begin
                        nxt_d.st = ST_RUN;
                    end else begin
                        nxt_d.st = ST_STEP;
                    end
                end
            end
            ST_STEP:   nxt_d.st = ST_DEBUG;
            default:   nxt_d.st = ST_HRST;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '{st: ST_HRST};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign in_reset = (cur_q.st == ST_RESET);

    core_rst_tick #(
        .PERIOD (PERIOD)
    ) u_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (in_reset),
        .at_zero_o (tick_zero)
    );

    assign beat = in_reset && tick_zero;

    always_comb begin
        fsel = FSEL_NONE;
        if (beat || cur_q.st == ST_LEAVE) begin
            fsel = FSEL_RESET;
        end else if (cur_q.st == ST_DENTER) begin
            fsel = FSEL_BREAK;
        end
    end

    core_rst_fetch_mux #(
        .ADDR_W     (ADDR_W),
        .RESET_ADDR (RESET_ADDR),
        .BREAK_ADDR (BREAK_ADDR)
    ) u_fmux (
        .sel_i  (fsel),
        .vld_o  (fetch_vld_o),
        .addr_o (fetch_addr_o)
    );

    assign core_rst_o      = (cur_q.st == ST_HRST) || in_reset;
    assign stall_o         = core_rst_o || (cur_q.st == ST_DRAIN);
    assign rst_taken_o     = beat;
    assign fetch_discard_o = beat;
    assign dbg_ack_o       = (cur_q.st == ST_DENTER) || (cur_q.st == ST_DEBUG)
                          || (cur_q.st == ST_STEP);
    assign step_go_o       = (cur_q.st == ST_STEP);

endmodule

// File: rtl/core_rst_seq_chk.sv
module core_rst_seq_chk #(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    parameter logic [ADDR_W-1:0] BREAK_ADDR = '0
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              lrst_req_i,
    input logic              pipe_empty_i,
    input logic              step_i,
    input logic              resume_i,
    input logic              core_rst_o,
    input logic              stall_o,
    input logic              rst_taken_o,
    input logic              dbg_ack_o,
    input logic              step_go_o,
    input logic              fetch_vld_o,
    input logic              fetch_discard_o,
    input logic [ADDR_W-1:0] fetch_addr_o
);

    logic armed = 1'b0;
    always @(posedge clk_i) armed <= 1'b1;

    // R1: hard reset holds the core with no acknowledge
    always @(posedge clk_i) begin
        if (armed && !rst_ni) begin
            assert_hard_hold_R1: assert (core_rst_o && stall_o && !dbg_ack_o && !rst_taken_o);
        end
    end

    assert_entry_after_drain_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(core_rst_o) |-> ($past(stall_o) && $past(pipe_empty_i) && rst_taken_o));

    assert_taken_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_taken_o |=> !rst_taken_o);

    assert_dummy_fetch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_taken_o |-> (fetch_vld_o && fetch_discard_o && fetch_addr_o == RESET_ADDR));

    assert_discard_only_in_reset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fetch_discard_o |-> core_rst_o);

    assert_hold_while_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (core_rst_o && lrst_req_i && $past(rst_ni)) |=> core_rst_o);

    assert_break_redirect_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(dbg_ack_o) |-> (fetch_vld_o && !fetch_discard_o && fetch_addr_o == BREAK_ADDR));

    assert_paused_ignores_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dbg_ack_o && !step_i && !resume_i) |=> (dbg_ack_o && !stall_o && !core_rst_o));

    assert_resume_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dbg_ack_o && !fetch_vld_o && !step_go_o && resume_i) |=> !dbg_ack_o);

    assert_step_or_drain_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dbg_ack_o && !fetch_vld_o && !step_go_o && step_i && !resume_i && lrst_req_i)
            |=> (stall_o && !dbg_ack_o));

endmodule

bind core_rst_seq core_rst_seq_chk #(
    .ADDR_W     (ADDR_W),
    .RESET_ADDR (RESET_ADDR),
    .BREAK_ADDR (BREAK_ADDR)
) u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .lrst_req_i      (lrst_req_i),
    .pipe_empty_i    (pipe_empty_i),
    .step_i          (step_i),
    .resume_i        (resume_i),
    .core_rst_o      (core_rst_o),
    .stall_o         (stall_o),
    .rst_taken_o     (rst_taken_o),
    .dbg_ack_o       (dbg_ack_o),
    .step_go_o       (step_go_o),
    .fetch_vld_o     (fetch_vld_o),
    .fetch_discard_o (fetch_discard_o),
    .fetch_addr_o    (fetch_addr_o)
);

// File: tb/tb_core_rst_seq.sv
module tb_core_rst_seq;

    localparam int             AW = 16;
    localparam int             P  = 5;
    localparam logic [AW-1:0]  RA = 16'h0100;
    localparam logic [AW-1:0]  BA = 16'h0820;

    // output vector order: {core_rst, stall, taken, ack, step_go, vld, discard}
    localparam logic [6:0] O_RUN    = 7'b0000000;
    localparam logic [6:0] O_DRAIN  = 7'b0100000;
    localparam logic [6:0] O_HELD   = 7'b1100000;
    localparam logic [6:0] O_PULSE  = 7'b1110011;
    localparam logic [6:0] O_LEAVE  = 7'b0000010;
    localparam logic [6:0] O_DENTER = 7'b0001010;
    localparam logic [6:0] O_DEBUG  = 7'b0001000;
    localparam logic [6:0] O_STEP   = 7'b0001100;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          lrst_req_i = 1'b0;
    logic          pipe_empty_i = 1'b0;
    logic          dbg_req_i = 1'b0;
    logic          step_i = 1'b0;
    logic          resume_i = 1'b0;
    logic          core_rst_o, stall_o, rst_taken_o, dbg_ack_o, step_go_o;
    logic          fetch_vld_o, fetch_discard_o;
    logic [AW-1:0] fetch_addr_o;

    int tests = 0;
    int fails = 0;

    always #4 clk_i = ~clk_i;

    core_rst_seq #(
        .ADDR_W     (AW),
        .PERIOD     (P),
        .RESET_ADDR (RA),
        .BREAK_ADDR (BA)
    ) dut (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .lrst_req_i      (lrst_req_i),
        .pipe_empty_i    (pipe_empty_i),
        .dbg_req_i       (dbg_req_i),
        .step_i          (step_i),
        .resume_i        (resume_i),
        .core_rst_o      (core_rst_o),
        .stall_o         (stall_o),
        .rst_taken_o     (rst_taken_o),
        .dbg_ack_o       (dbg_ack_o),
        .step_go_o       (step_go_o),
        .fetch_vld_o     (fetch_vld_o),
        .fetch_discard_o (fetch_discard_o),
        .fetch_addr_o    (fetch_addr_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_o(input string tag, input logic [6:0] e, input logic [AW-1:0] ea);
        check(tag, 32'({core_rst_o, stall_o, rst_taken_o, dbg_ack_o,
                        step_go_o, fetch_vld_o, fetch_discard_o}), 32'(e));
        if (e[1]) check({tag, " addr"}, 32'(fetch_addr_o), 32'(ea));
    endtask

    task automatic tick();
        @(posedge clk_i);
        #2;
    endtask

    // local reset with drain delay d and hold of h cycles past entry
    task automatic local_reset(input int d, input int h);
        int pulses;
        lrst_req_i = 1'b1;
        pipe_empty_i = 1'b0;
        tick();
        expect_o("R2 drain begins", O_DRAIN, RA);
        for (int k = 0; k < d; k++) begin
            tick();
            expect_o("R2 waits for empty pipeline", O_DRAIN, RA);
        end
        pipe_empty_i = 1'b1;
        tick();
        expect_o("R3 entry pulse", O_PULSE, RA);
        pipe_empty_i = 1'b0;
        pulses = 1;
        for (int i = 1; i <= h; i++) begin
            tick();
            expect_o("R3 R4 periodic pulse and dummy fetch",
                     (i % P == 0) ? O_PULSE : O_HELD, RA);
            if (rst_taken_o) pulses++;
        end
        check("R3 pulse count", 32'(pulses), 32'(h / P + 1));
        lrst_req_i = 1'b0;
        tick();
        expect_o("R5 restart fetch", O_LEAVE, RA);
        tick();
        expect_o("R5 running", O_RUN, RA);
    endtask

    task automatic enter_debug();
        dbg_req_i = 1'b1;
        tick();
        expect_o("R6 break redirect", O_DENTER, BA);
        dbg_req_i = 1'b0;
        tick();
        expect_o("R6 paused", O_DEBUG, BA);
    endtask

    task automatic finish_drain();
        pipe_empty_i = 1'b1;
        tick();
        expect_o("R2 entry after drain", O_PULSE, RA);
        pipe_empty_i = 1'b0;
        lrst_req_i = 1'b0;
        tick();
        expect_o("R5 restart", O_LEAVE, RA);
        tick();
    endtask

    initial begin
        #(8 * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: global reset
        repeat (3) tick();
        expect_o("R1 held in hard reset", O_HELD, RA);
        rst_ni = 1'b1;
        tick();
        expect_o("R1 restart fetch after hard reset", O_LEAVE, RA);
        tick();
        expect_o("R1 running", O_RUN, RA);

        // R2 R3 R4 R5 sweep
        for (int d = 0; d < 4; d++) begin
            for (int h = 0; h < 13; h++) begin
                local_reset(d, h);
            end
        end

        // R12: request withdrawn during drain
        lrst_req_i = 1'b1;
        tick();
        expect_o("R12 drain begins", O_DRAIN, RA);
        lrst_req_i = 1'b0;
        repeat (2) begin
            tick();
            expect_o("R12 drain continues after withdraw", O_DRAIN, RA);
        end
        pipe_empty_i = 1'b1;
        tick();
        expect_o("R12 reset still entered", O_PULSE, RA);
        pipe_empty_i = 1'b0;
        tick();
        expect_o("R12 leaves after one cycle", O_LEAVE, RA);
        tick();

        // R11: local reset beats debug, debug ignored in drain/reset
        lrst_req_i = 1'b1;
        dbg_req_i = 1'b1;
        tick();
        expect_o("R11 local reset wins", O_DRAIN, RA);
        tick();
        expect_o("R11 debug ignored in drain", O_DRAIN, RA);
        pipe_empty_i = 1'b1;
        tick();
        expect_o("R11 entry", O_PULSE, RA);
        pipe_empty_i = 1'b0;
        tick();
        expect_o("R11 debug ignored in reset", O_HELD, RA);
        lrst_req_i = 1'b0;
        tick();
        expect_o("R11 debug ignored in restart", O_LEAVE, RA);
        dbg_req_i = 1'b0;
        tick();
        expect_o("R11 running", O_RUN, RA);

        // R6 R7 R8 R9 R10
        enter_debug();
        dbg_req_i = 1'b1;
        repeat (3) begin
            tick();
            expect_o("R7 repeat debug request no effect", O_DEBUG, BA);
        end
        dbg_req_i = 1'b0;
        lrst_req_i = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick();
            expect_o("R8 local reset ignored while paused", O_DEBUG, BA);
        end
        lrst_req_i = 1'b0;
        step_i = 1'b1;
        tick();
        expect_o("R10 single step window", O_STEP, BA);
        step_i = 1'b0;
        tick();
        expect_o("R10 paused after step", O_DEBUG, BA);
        step_i = 1'b1;
        lrst_req_i = 1'b1;
        tick();
        expect_o("R10 reset honoured at step", O_DRAIN, RA);
        step_i = 1'b0;
        finish_drain();
        expect_o("R10 running after reset", O_RUN, RA);

        enter_debug();
        resume_i = 1'b1;
        tick();
        expect_o("R9 resume clears ack", O_RUN, RA);
        resume_i = 1'b0;
        enter_debug();
        resume_i = 1'b1;
        step_i = 1'b1;
        lrst_req_i = 1'b1;
        tick();
        expect_o("R9 reset honoured at resume", O_DRAIN, RA);
        resume_i = 1'b0;
        step_i = 1'b0;
        finish_drain();

        enter_debug();
        resume_i = 1'b1;
        step_i = 1'b1;
        tick();
        expect_o("R9 resume wins over step", O_RUN, RA);
        resume_i = 1'b0;
        step_i = 1'b0;

        // R1: hard reset while paused, asynchronous effect
        enter_debug();
        rst_ni = 1'b0;
        #1;
        expect_o("R1 immediate hard reset clears ack", O_HELD, RA);
        tick();
        tick();
        rst_ni = 1'b1;
        tick();
        expect_o("R1 restart after hard reset", O_LEAVE, RA);
        tick();
        expect_o("R1 running again", O_RUN, RA);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule